// File: doc/BRIEF.md
# Single-Register I2C Configuration Target

This block is an I2C target that owns one 8-bit configuration register for a power-regulator style device. It runs on a system clock. SCL and SDA are brought into that clock domain through flop synchronizers, and then scanned for START and STOP conditions and for clock edges. The block answers to one fixed 7-bit bus address. It never drives SDA high. Its only output on the bus is a pull-down enable, which the pad turns into an open-drain low.

A controller writes the register with three bytes. The first is the address byte with the direction bit clear, the second is a register index, and the third is the data byte. The new value is only staged at that point. It reaches the register output when a STOP closes a transfer in which the data byte was fully received and acknowledged and the index was zero. On that same clock edge a single-cycle apply strobe tells downstream logic to reconfigure.

A read sets the index with a write-direction address byte. A repeated START, or a STOP followed by a START, then comes before an address byte with the direction bit set. The block then shifts the register out MSB first, and the controller ends the read with NACK and STOP. START is not honoured while the enable input is low or while the power-up busy input is high. The bus side carries no data stream with back-pressure, so every pin here is a plain level or strobe.

Top module: `cfg_i2c_target`

## Requirements
- R1: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are detected on the synchronized lines. Before the first START, bytes clocked on the bus get no acknowledge.
- R2: The first byte after a START is acknowledged only when its upper seven bits equal 0x1C. Its LSB selects read (1) or write (0). For any other address the SDA pull stays off for the rest of that transfer.
- R3: In a write, the address, index and data bytes are each acknowledged by pulling SDA low during the ninth SCL clock. The register then takes the data value at the STOP.
- R4: A read, reached by either a repeated START or a STOP then START, acknowledges the address byte and then presents the register MSB first. Each bit is valid while SCL is high.
- R5: A STOP that comes before the data byte and its acknowledge are complete leaves the register and the apply strobe untouched. This includes a STOP right after the index byte and a STOP in the middle of the data byte.
- R6: Each committing STOP produces exactly one apply pulse, one system clock long. It is issued on the same edge that updates the register, and the register changes at no other time.
- R7: A write whose index is not 0x00 is acknowledged but discarded at STOP. A read with any index returns the register.
- R8: A second data byte in a write gets no acknowledge, and the write is then discarded.
- R9: While the enable input is low, START is ignored and SDA is never pulled.
- R10: While the power-up busy input is high, START is ignored and the transfer that follows gets no acknowledge and changes nothing.
- R11: After reset the register reads 0x00, the apply strobe is low and SDA is released.
- R12: The SDA pull is only switched on while SCL is low, so it never forms a bus condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| enable | input | 1 | Block enable; when low, START is ignored |
| pwr_busy | input | 1 | High while power-up is in progress; START is ignored |
| cfg_value | output | 8 | Committed configuration register |
| apply_pulse | output | 1 | One-cycle strobe when a new value is committed |

## Verification
The register update and the apply strobe are two separate functions, and they land on the same clock edge. The bench watches the register output on every cycle. Any change in its value has to coincide with the strobe, and every write in the data sweep has to add exactly one strobe. A second pairing comes from a commit followed directly by a START for a read. The bench runs both paths, repeated START and STOP then START, after each swept write, so the read sees the value that was just committed.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_HOLD
  } xfer_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_INDEX,
    BK_DATA,
    BK_EXTRA
  } byte_kind_e;
endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else if (g == 0) stage_q[g] <= din;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_i2c_bus_cond.sv
module cfg_i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/cfg_i2c_xfer.sv
module cfg_i2c_xfer
  import cfg_i2c_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            AW      = 7,
  parameter logic [AW-1:0] DEV_ADR = 7'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          busy,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  output logic          sda_pull,
  output logic [DW-1:0] cfg_q,
  output logic          apply_q
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  xfer_state_e  state;
  byte_kind_e   kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, staged, txsh;
  logic          rd, idx_ok, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= BK_ADDR;
      cnt     <= '0;
      sh      <= '0;
      staged  <= '0;
      txsh    <= '0;
      rd      <= 1'b0;
      idx_ok  <= 1'b0;
      armed   <= 1'b0;
      cfg_q   <= '0;
      apply_q <= 1'b0;
    end else begin
      apply_q <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        armed <= 1'b0;
      end else if (stop_det) begin
        if (armed && idx_ok) begin
          cfg_q   <= staged;
          apply_q <= 1'b1;
        end
        state <= ST_IDLE;
        armed <= 1'b0;
      end else if (start_det && !busy) begin
        state <= ST_RX;
        kind  <= BK_ADDR;
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (kind == BK_EXTRA && cnt != '0) armed <= 1'b0;
            end else if (scl_fall && cnt == FULL) begin
              unique case (kind)
                BK_ADDR: begin
                  if (sh[DW-1:DW-AW] == DEV_ADR) begin
                    state <= ST_ACK;
                    rd    <= sh[0];
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                BK_INDEX: begin
                  state  <= ST_ACK;
                  idx_ok <= (sh == '0);
                end
                BK_DATA: begin
                  state  <= ST_ACK;
                  staged <= sh;
                end
                default: begin
                  state <= ST_HOLD;
                  armed <= 1'b0;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              unique case (kind)
                BK_ADDR: begin
                  if (rd) begin
                    state <= ST_TX;
                    txsh  <= cfg_q;
                  end else begin
                    state <= ST_RX;
                    kind  <= BK_INDEX;
                  end
                end
                BK_INDEX: begin
                  state <= ST_RX;
                  kind  <= BK_DATA;
                end
                default: begin
                  state <= ST_RX;
                  kind  <= BK_EXTRA;
                  armed <= 1'b1;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                state <= ST_TXACK;
              end else begin
                txsh <= {txsh[DW-2:0], 1'b0};
                cnt  <= cnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_fall) state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = (state == ST_ACK) | ((state == ST_TX) & ~txsh[DW-1]);
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int           DW        = 8,
  parameter int           AW        = 7,
  parameter int           SYNC_LEN  = 2,
  parameter logic [AW-1:0] DEV_ADR  = 7'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  input  logic          enable,
  input  logic          pwr_busy,
  output logic [DW-1:0] cfg_value,
  output logic          apply_pulse
);
  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;

  cfg_i2c_sync #(.W(2), .STAGES(SYNC_LEN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout ({scl_s, sda_s})
  );

  cfg_i2c_bus_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  cfg_i2c_xfer #(.DW(DW), .AW(AW), .DEV_ADR(DEV_ADR)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .busy     (pwr_busy),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .sda_pull (sda_pull),
    .cfg_q    (cfg_value),
    .apply_q  (apply_pulse)
  );
endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sda_pull,
  input logic          apply_pulse,
  input logic [DW-1:0] cfg_value,
  input logic          stop_det,
  input logic          scl_s
);
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_pull);

  p_apply_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |-> $past(stop_det));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |=> !apply_pulse);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_pulse |-> $stable(cfg_value));

  p_pull_on_low_scl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
endmodule

bind cfg_i2c_target cfg_i2c_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (enable),
  .sda_pull   (sda_pull),
  .apply_pulse(apply_pulse),
  .cfg_value  (cfg_value),
  .stop_det   (stop_det),
  .scl_s      (scl_s)
);

// File: tb/cfg_i2c_target_test.sv
`timescale 1ns/1ps
module cfg_i2c_target_test;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic enable = 1'b1;
  logic pwr_busy = 1'b0;
  logic sda_pull, apply_pulse;
  logic [7:0] cfg_value;
  logic sda_line;

  int total = 0;
  int bad = 0;
  int apply_cnt = 0;
  int pull_cnt = 0;
  logic [7:0] exp_cfg = 8'h00;
  logic [7:0] prev_cfg = 8'h00;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  cfg_i2c_target uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .sda_pull   (sda_pull),
    .enable     (enable),
    .pwr_busy   (pwr_busy),
    .cfg_value  (cfg_value),
    .apply_pulse(apply_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6: the register may only change on the cycle that carries the strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (apply_pulse) apply_cnt++;
      if (sda_pull) pull_cnt++;
      if (cfg_value !== prev_cfg) chk(apply_pulse === 1'b1, "R6 change without strobe", apply_pulse, 1);
      prev_cfg = cfg_value;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic wbit(input logic v);
    sda_m = v; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    acked = ~sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv(output logic [7:0] d, input logic nack);
    d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq();
      scl_m = 1'b1; wq();
      d = {d[6:0], sda_line}; wq();
      scl_m = 1'b0; wq();
    end
    wbit(nack);
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] d,
                          output bit a1, output bit a2, output bit a3);
    bus_start();
    send(8'h38, a1);
    send(idx, a2);
    send(d, a3);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] idx, input bit rep, output logic [7:0] d,
                         output bit a1, output bit a2, output bit a3);
    bus_start();
    send(8'h38, a1);
    send(idx, a2);
    if (!rep) bus_stop();
    bus_start();
    send(8'h39, a3);
    recv(d, 1'b1);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a1, a2, a3, a4;
    logic [7:0] d;
    int ap0, pl0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(cfg_value == 8'h00, "R11 reset value", cfg_value, 0);
    chk(apply_pulse == 1'b0, "R11 strobe low", apply_pulse, 0);
    chk(sda_pull == 1'b0, "R11 sda released", sda_pull, 0);

    // R1: byte without START
    pl0 = pull_cnt;
    send(8'h38, a1);
    chk(!a1 && pull_cnt == pl0, "R1 no ack before start", pull_cnt - pl0, 0);
    bus_stop();

    // R2: address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send({a[6:0], 1'b0}, a1);
      bus_stop();
      chk(a1 == (a == 28), "R2 address match", a1, (a == 28));
    end

    // R3 R4 R6: data sweep with readback over both read paths
    for (int v = 0; v < 256; v += 15) begin
      ap0 = apply_cnt;
      do_write(8'h00, v[7:0], a1, a2, a3);
      wq();
      exp_cfg = v[7:0];
      chk(a1 && a2 && a3, "R3 write acks", {a1, a2, a3}, 7);
      chk(cfg_value == exp_cfg, "R3 committed value", cfg_value, exp_cfg);
      chk(apply_cnt == ap0 + 1, "R6 one strobe per write", apply_cnt - ap0, 1);
      do_read(8'h00, (v % 2) == 0, d, a1, a2, a3);
      chk(a3, "R4 read address ack", a3, 1);
      chk(d == exp_cfg, "R4 readback", d, exp_cfg);
    end

    // R5: STOP right after index byte
    ap0 = apply_cnt;
    bus_start(); send(8'h38, a1); send(8'h00, a2); bus_stop();
    chk(cfg_value == exp_cfg && apply_cnt == ap0, "R5 stop after index", cfg_value, exp_cfg);

    // R5: STOP in the middle of the data byte
    bus_start(); send(8'h38, a1); send(8'h00, a2);
    wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
    bus_stop();
    chk(cfg_value == exp_cfg && apply_cnt == ap0, "R5 stop mid data", cfg_value, exp_cfg);

    // R7: nonzero index write discarded, read any index
    do_write(8'h05, 8'hA5, a1, a2, a3);
    wq();
    chk(a3, "R7 data acked", a3, 1);
    chk(cfg_value == exp_cfg && apply_cnt == ap0, "R7 write discarded", cfg_value, exp_cfg);
    do_read(8'h05, 1'b1, d, a1, a2, a3);
    chk(d == exp_cfg, "R7 read other index", d, exp_cfg);

    // R8: second data byte
    bus_start(); send(8'h38, a1); send(8'h00, a2); send(8'h77, a3); send(8'h11, a4); bus_stop();
    wq();
    chk(a3 && !a4, "R8 extra byte not acked", {a3, a4}, 2);
    chk(cfg_value == exp_cfg && apply_cnt == ap0, "R8 write discarded", cfg_value, exp_cfg);

    // R9: disabled
    enable = 1'b0;
    pl0 = pull_cnt;
    do_write(8'h00, 8'h3C, a1, a2, a3);
    wq();
    chk(!a1 && !a2 && !a3 && pull_cnt == pl0, "R9 no pull when disabled", pull_cnt - pl0, 0);
    chk(cfg_value == exp_cfg, "R9 register kept", cfg_value, exp_cfg);
    enable = 1'b1;

    // R10: power-up busy
    pwr_busy = 1'b1;
    do_write(8'h00, 8'hC3, a1, a2, a3);
    wq();
    chk(!a1 && !a2 && !a3, "R10 no ack while busy", {a1, a2, a3}, 0);
    chk(cfg_value == exp_cfg && apply_cnt == ap0, "R10 register kept", cfg_value, exp_cfg);
    pwr_busy = 1'b0;

    // R3: final commit after the refused cases
    do_write(8'h00, 8'h5A, a1, a2, a3);
    wq();
    exp_cfg = 8'h5A;
    chk(cfg_value == exp_cfg && apply_cnt == ap0 + 1, "R3 commit after recovery", cfg_value, exp_cfg);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule